// File: doc/BRIEF.md
# Serial Line Baud Rate Detector

This block sits beside a UART on the host transmit-data line. After it is armed, it waits for the line to rest high and then for the falling edge of a start bit. It counts how many clock cycles the line stays low. The count is compared against a set of standard bit times, and the block picks the rate whose tolerance window contains it. On a match it presents the rate code and the clock divisor for that rate. It also raises a one-cycle lock pulse, which tells the UART to take the divisor and tells the command parser to begin its search.

The rates form a doubling ladder. The fastest rate has a bit time of `BASE_DIV` clock cycles, which is 1152 cycles at 9600 bps from an 11.0592 MHz clock. The ladder has `NUM_RATES` steps, so with the default values it covers 300 to 9600 bps.

A low pulse shorter than half the fastest bit time is treated as line noise and dropped. A longer pulse that falls outside every window raises a one-cycle error pulse. In both cases the search goes on with the next character. Once the block has locked, it holds its result until it is armed again.

Top module: `autobaud_detect`

## Requirements
- R1: After reset, `rate_code` and `divisor` are 0, `locked` and `rate_err` are low, and the detector is disarmed: low pulses on `host_txd` produce no pulse until `arm` is raised.
- R2: A one-cycle `arm` pulse, given in any state, restarts the search. If the line is low when `arm` arrives, that low period is not measured; measurement starts only with a falling edge after the line has been seen high.
- R3: The measured value is the number of clock cycles the synchronised line stays low. For code k (0 slowest to NUM_RATES-1 fastest), the divisor is BASE_DIV<<(NUM_RATES-1-k). The window for code k is divisor ± floor(divisor*TOL_PCT/100), inclusive at both ends.
- R4: A measurement inside a window gives `locked` high for exactly one cycle, at most 4 cycles after the line returns high. In that same cycle `rate_code` and `divisor` show the matched rate.
- R5: A measurement of at least BASE_DIV/2 that lies in no window gives `rate_err` high for one cycle and leaves the search active. A low period longer than the counter can hold (2^CNT_W-1) saturates the count and is reported the same way.
- R6: A low period shorter than BASE_DIV/2 cycles produces neither `locked` nor `rate_err`, and the search stays active.
- R7: After a lock, further line activity produces no pulse, and `rate_code` and `divisor` stay unchanged until the next `arm`.
- R8: `locked` and `rate_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_txd | input | 1 | Host transmit-data line (idle high), asynchronous |
| arm | input | 1 | One-cycle pulse that starts a new rate search |
| rate_code | output | $clog2(NUM_RATES) | Selected rate, 0 = slowest |
| divisor | output | CNT_W | Clock cycles per bit for the selected rate |
| locked | output | 1 | One-cycle pulse when a rate is accepted |
| rate_err | output | 1 | One-cycle pulse when a measurement matches no rate |

## Verification
Several properties are checked by assertions on every cycle: the lock and error pulses never overlap, each pulse lasts one cycle, the rate code stays in range, the divisor always agrees with the rate code when a lock fires, and both outputs stay stable in every cycle without a lock. Other behaviour can only be shown by the bench's scenarios. These are the exact window edges for every rate, with one cycle inside and one outside each edge; the noise threshold; counter saturation; the result being held after lock; and a low line at the moment of arming being ignored.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_HIGH,
        ST_WAIT_START,
        ST_MEASURE,
        ST_LOCKED
    } ab_state_e;
endpackage

// File: rtl/ab_line_sync.sv
module ab_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    // Shift chain resets to the idle-high line level.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/ab_rate_match.sv
module ab_rate_match #(
    parameter int BASE_DIV  = 1152,
    parameter int NUM_RATES = 6,
    parameter int TOL_PCT   = 12,
    parameter int CNT_W     = 16,
    parameter int CODE_W    = $clog2(NUM_RATES)
) (
    input  logic [CNT_W-1:0]  count_i,
    output logic              hit_o,
    output logic [CODE_W-1:0] code_o,
    output logic [CNT_W-1:0]  div_o
);
    logic [31:0]          cnt_ext;
    logic [NUM_RATES-1:0] hit;

    assign cnt_ext = 32'(count_i);

    // One window comparator per rate; windows do not overlap.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
        localparam int DIVG = BASE_DIV << (NUM_RATES - 1 - g);
        localparam int TOLG = (DIVG * TOL_PCT) / 100;
        assign hit[g] = (cnt_ext >= 32'(DIVG - TOLG)) && (cnt_ext <= 32'(DIVG + TOLG));
    end

    assign hit_o = |hit;

    always_comb begin
        code_o = '0;
        div_o  = '0;
        for (int k = 0; k < NUM_RATES; k++) begin
            if (hit[k]) begin
                code_o = CODE_W'(k);
                div_o  = CNT_W'(BASE_DIV << (NUM_RATES - 1 - k));
            end
        end
    end
endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
    import autobaud_pkg::*;
#(
    parameter int BASE_DIV    = 1152,
    parameter int NUM_RATES   = 6,
    parameter int TOL_PCT     = 12,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CODE_W     = $clog2(NUM_RATES),
    localparam int GLITCH_MIN = BASE_DIV / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_txd,
    input  logic              arm,
    output logic [CODE_W-1:0] rate_code,
    output logic [CNT_W-1:0]  divisor,
    output logic              locked,
    output logic              rate_err
);
    typedef struct packed {
        ab_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  div;
        logic              lock;
        logic              err;
    } regs_t;

    regs_t             r_d, r_q;
    logic              line_s;
    logic              m_hit;
    logic [CODE_W-1:0] m_code;
    logic [CNT_W-1:0]  m_div;

    ab_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (host_txd),
        .dout (line_s)
    );

    ab_rate_match #(
        .BASE_DIV (BASE_DIV),
        .NUM_RATES(NUM_RATES),
        .TOL_PCT  (TOL_PCT),
        .CNT_W    (CNT_W),
        .CODE_W   (CODE_W)
    ) u_match (
        .count_i(r_q.cnt),
        .hit_o  (m_hit),
        .code_o (m_code),
        .div_o  (m_div)
    );

    always_comb begin
        r_d      = r_q;
        r_d.lock = 1'b0;
        r_d.err  = 1'b0;
        if (arm) begin
            r_d.st  = ST_WAIT_HIGH;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_WAIT_HIGH:  if (line_s) r_d.st = ST_WAIT_START;
                ST_WAIT_START: begin
                    if (!line_s) begin
                        r_d.st  = ST_MEASURE;
                        r_d.cnt = CNT_W'(1);
                    end
                end
                ST_MEASURE: begin
                    if (!line_s) begin
                        if (r_q.cnt != '1) r_d.cnt = r_q.cnt + 1'b1;
                    end else if (32'(r_q.cnt) < 32'(GLITCH_MIN)) begin
                        r_d.st = ST_WAIT_START;
                    end else if (m_hit) begin
                        r_d.st   = ST_LOCKED;
                        r_d.code = m_code;
                        r_d.div  = m_div;
                        r_d.lock = 1'b1;
                    end else begin
                        r_d.st  = ST_WAIT_START;
                        r_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.code <= '0;
            r_q.div  <= '0;
            r_q.lock <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rate_code = r_q.code;
    assign divisor   = r_q.div;
    assign locked    = r_q.lock;
    assign rate_err  = r_q.err;
endmodule

// File: rtl/autobaud_detect_chk.sv
module autobaud_detect_chk #(
    parameter int BASE_DIV  = 1152,
    parameter int NUM_RATES = 6,
    parameter int CNT_W     = 16,
    parameter int CODE_W    = $clog2(NUM_RATES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] rate_code,
    input logic [CNT_W-1:0]  divisor,
    input logic              locked,
    input logic              rate_err
);
    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && rate_err));

    p_lock_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !locked);

    p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |=> !rate_err);

    p_lock_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (32'(divisor) == 32'(BASE_DIV << (NUM_RATES - 1 - int'(rate_code)))));

    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rate_code) <= 32'(NUM_RATES - 1));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> ($stable(divisor) && $stable(rate_code)));
endmodule

bind autobaud_detect autobaud_detect_chk #(
    .BASE_DIV (BASE_DIV),
    .NUM_RATES(NUM_RATES),
    .CNT_W    (CNT_W),
    .CODE_W   (CODE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_code(rate_code),
    .divisor  (divisor),
    .locked   (locked),
    .rate_err (rate_err)
);

// File: tb/autobaud_detect_tb.sv
module autobaud_detect_tb;
    localparam int BASE  = 48;
    localparam int NR    = 6;
    localparam int TOL   = 12;
    localparam int CW    = 12;
    localparam int CODEW = $clog2(NR);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_txd = 1'b1;
    logic             arm = 1'b0;
    logic [CODEW-1:0] rate_code;
    logic [CW-1:0]    divisor;
    logic             locked;
    logic             rate_err;

    int checks = 0;
    int fails  = 0;

    // Results of the last observation window.
    int n_lock, n_err, got_code, got_div;

    always #4 clk = ~clk;

    autobaud_detect #(
        .BASE_DIV (BASE),
        .NUM_RATES(NR),
        .TOL_PCT  (TOL),
        .CNT_W    (CW)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_txd (host_txd),
        .arm      (arm),
        .rate_code(rate_code),
        .divisor  (divisor),
        .locked   (locked),
        .rate_err (rate_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int div_of(input int k);
        return BASE << (NR - 1 - k);
    endfunction

    // Expected outcome: 0 none, 1 lock, 2 error; code in exp_k.
    function automatic int expect_kind(input int n, output int exp_k);
        int m;
        exp_k = 0;
        m = (n > (1 << CW) - 1) ? (1 << CW) - 1 : n;
        if (m < BASE / 2) return 0;
        for (int k = 0; k < NR; k++) begin
            int d = div_of(k);
            int t = (d * TOL) / 100;
            if (m >= d - t && m <= d + t) begin
                exp_k = k;
                return 1;
            end
        end
        return 2;
    endfunction

    task automatic arm_pulse();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic observe();
        n_lock = 0; n_err = 0; got_code = -1; got_div = -1;
        repeat (10) begin
            @(negedge clk);
            if (locked) begin
                n_lock++;
                got_code = int'(rate_code);
                got_div  = int'(divisor);
            end
            if (rate_err) n_err++;
            if (locked && rate_err) n_err += 100;
        end
    endtask

    task automatic send_low(input int n);
        @(negedge clk) host_txd = 1'b0;
        repeat (n) @(negedge clk);
        host_txd = 1'b1;
        observe();
    endtask

    task automatic probe(input int n, input string req);
        int ek, kind;
        kind = expect_kind(n, ek);
        send_low(n);
        check(n_lock == (kind == 1 ? 1 : 0), req, $sformatf("lock pulses n=%0d", n), n_lock, kind == 1 ? 1 : 0);
        check(n_err == (kind == 2 ? 1 : 0), req, $sformatf("err pulses n=%0d", n), n_err, kind == 2 ? 1 : 0);
        if (kind == 1) begin
            check(got_code == ek, req, $sformatf("rate code n=%0d", n), got_code, ek);
            check(got_div == div_of(ek), req, $sformatf("divisor n=%0d", n), got_div, div_of(ek));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check(rate_code == '0, "R1", "reset rate_code", int'(rate_code), 0);
        check(divisor == '0, "R1", "reset divisor", int'(divisor), 0);
        check(!locked && !rate_err, "R1", "reset pulses", int'(locked) + int'(rate_err), 0);
        // R1: disarmed detector ignores a valid start bit
        probe(0, "R1");
        send_low(96);
        check(n_lock == 0 && n_err == 0, "R1", "pulses before arm", n_lock + n_err, 0);

        // R3 R4 R5: window edges for every rate
        for (int k = 0; k < NR; k++) begin
            int d = div_of(k);
            int t = (d * TOL) / 100;
            int pts[5];
            pts = '{d - t - 1, d - t, d, d + t, d + t + 1};
            foreach (pts[i]) begin
                arm_pulse();
                probe(pts[i], "R3");
            end
        end

        // R6: noise pulses dropped, search continues
        arm_pulse();
        probe(1, "R6");
        probe(BASE / 2 - 1, "R6");
        probe(BASE, "R6");

        // R5: threshold value is an error, search continues
        arm_pulse();
        probe(BASE / 2, "R5");
        probe(BASE * 2, "R5");

        // R5: saturation of the counter
        arm_pulse();
        probe(5000, "R5");

        // R7: result held after lock
        arm_pulse();
        probe(BASE * 2, "R7");
        send_low(BASE * 32);
        check(n_lock == 0 && n_err == 0, "R7", "pulses while locked", n_lock + n_err, 0);
        check(int'(rate_code) == NR - 2, "R7", "held code", int'(rate_code), NR - 2);
        check(int'(divisor) == BASE * 2, "R7", "held divisor", int'(divisor), BASE * 2);
        arm_pulse();
        probe(BASE * 32, "R7");

        // R2: low line at arm time not measured
        @(negedge clk) host_txd = 1'b0;
        repeat (5) @(negedge clk);
        arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        repeat (BASE * 2) @(negedge clk);
        host_txd = 1'b1;
        observe();
        check(n_lock == 0 && n_err == 0, "R2", "pulses from low at arm", n_lock + n_err, 0);
        probe(BASE * 4, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule